// File: doc/BRIEF.md
# Multiword DMA Host Burst Sequencer

This block runs the host side of multiword DMA bursts on a 16-bit parallel disk data bus. It runs from one system clock. Every interface timing is given in nanoseconds as a parameter and turned into a whole number of clock cycles by rounding up. Software or a command engine starts a burst with a direction bit and a word count. The block then waits for the device's request line and asserts its active-low acknowledge. It issues one active-low read or write strobe pulse per word and moves words between the disk bus and a valid/ready word stream.

On reads, each word on the bus is captured as the strobe negates and is held on the read stream until it is accepted. On writes, a word is taken from the write stream as the strobe asserts and is driven onto the bus with an output enable. A burst ends when the word count runs out, or when the synchronized request is found low at the sample point that follows each strobe. A one-cycle done pulse marks the end. The acknowledge then stays asserted for its hold time before it is released.

Top module: `mdma_host_seq`

## Requirements
- R1: While reset is asserted, ack_n, rd_stb_n and wr_stb_n are high, and dd_oe, busy, rd_valid and done are low.
- R2: Each strobe pulse stays low for exactly ceil(70 ns / clock period) cycles, which is 4 cycles at 20 ns.
- R3: Between two strobe pulses of one burst, the strobe stays high for at least the largest of ceil(25/T), ceil(120/T) minus the low time, ceil(10/T), and ceil(35/T) plus the two synchronizer stages. That is 4 cycles at 20 ns.
- R4: ack_n falls at least one cycle before the first strobe of a burst. It rises only after at least ceil(5/T) cycles, with a minimum of 1, have passed since the last strobe went high. A burst starts only after the synchronized request is seen high.
- R5: On a read burst (dir_wr=0), dd_in is captured into rd_data on the edge where rd_stb_n rises. rd_valid then stays high with rd_data stable until rd_ready is accepted. No read strobe begins while rd_valid is high.
- R6: On a write burst (dir_wr=1), a word is taken when wr_valid and wr_ready are both high, on the edge where wr_stb_n falls. dd_out holds that word unchanged through the pulse and for at least one cycle after wr_stb_n rises. No write strobe begins without a word.
- R7: dd_oe is high only while ack_n is low in a write burst. It falls on the same edge on which ack_n rises.
- R8: A burst of word_count words, with the request held high, produces exactly word_count strobes and exactly one done pulse of one cycle.
- R9: If the request is low at the sample point after a strobe, the burst ends without a further strobe. The device receives exactly the words it requested, provided it drops the request within 35 ns of that strobe's rising edge.
- R10: A start with word_count equal to 0 yields a done pulse and never asserts ack_n.
- R11: Only the strobe that matches the latched direction is ever pulsed. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle burst start request |
| dir_wr | input | 1 | Burst direction, 1 = host to device |
| word_count | input | 16 | Words to transfer in the burst |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| dev_req | input | 1 | Device DMA request, asynchronous |
| ack_n | output | 1 | DMA acknowledge, active low |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| dd_in | input | 16 | Data bus value from the device |
| dd_out | output | 16 | Data bus value driven by the host |
| dd_oe | output | 1 | Data bus output enable |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | rd_data holds an unaccepted word |
| rd_ready | input | 1 | Consumer accepts rd_data |
| wr_data | input | 16 | Next word to write |
| wr_valid | input | 1 | wr_data is available |
| wr_ready | output | 1 | Sequencer takes wr_data this cycle |

## Verification
The bench goes after the request being withdrawn at three different times around the final strobe: during the pulse, half a cycle after it rises, and one and a half cycles after. A sequencer that sampled the request too early, before the synchronizer had caught up, would issue one strobe more than the device asked for. It also starves the write stream and stalls the read stream at random. A design that ignored either would strobe without data or overwrite an unread word, and the bench would see this as a miscompared word or a word count that does not match. Zero-length bursts and a start pulse injected in the middle of a burst check that ack_n stays idle and that the running burst is not disturbed. The strobe low and high widths and the acknowledge lead and tail are measured on every pulse, so a miscounted timer shows up as a cycle-count mismatch.

// File: rtl/mdma_host_seq.sv
`timescale 1ns/1ps
module mdma_host_seq #(
  parameter int CLK_NS      = 20,
  parameter int T_CYC_NS    = 120,
  parameter int T_ACT_NS    = 70,
  parameter int T_REC_NS    = 25,
  parameter int T_WSU_NS    = 20,
  parameter int T_WHOLD_NS  = 10,
  parameter int T_ACKH_NS   = 5,
  parameter int T_REQDLY_NS = 35,
  parameter int SYNC        = 2,
  parameter int DW          = 16,
  parameter int CW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_wr,
  input  logic [CW-1:0] word_count,
  output logic          busy,
  output logic          done,
  input  logic          dev_req,
  output logic          ack_n,
  output logic          rd_stb_n,
  output logic          wr_stb_n,
  input  logic [DW-1:0] dd_in,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_valid,
  output logic          wr_ready
);

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ACT_CK  = mx(mx(cdiv(T_ACT_NS), cdiv(T_WSU_NS)), 1);
  localparam int ACKH_CK = mx(cdiv(T_ACKH_NS), 1);
  localparam int NEG_LEN = mx(mx(mx(cdiv(T_REC_NS), cdiv(T_CYC_NS) - ACT_CK),
                                 mx(cdiv(T_WHOLD_NS), cdiv(T_REQDLY_NS) + SYNC)), 1);
  localparam int TMAX    = mx(mx(ACT_CK, ACKH_CK), NEG_LEN);
  localparam int TW      = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_WREQ, S_ARM, S_STB, S_NEG, S_HOLD} st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [CW-1:0]  rem;
  logic           dir;
  logic [SYNC-1:0] rq_sync;
  logic           req_s;
  logic           slot_end, more, go_slot, data_ok, launch;

  always_ff @(posedge clk) begin
    if (!rst_n) rq_sync <= '0;
    else        rq_sync <= {rq_sync[SYNC-2:0], dev_req};
  end

  assign req_s    = rq_sync[SYNC-1];
  assign slot_end = (st == S_NEG) && (tmr == '0);
  assign more     = (rem != '0) && req_s;
  assign go_slot  = ((st == S_ARM) && req_s) || (slot_end && more);
  assign data_ok  = dir ? wr_valid : !rd_valid;
  assign launch   = go_slot && data_ok;
  assign wr_ready = go_slot && dir;

  assign busy     = (st != S_IDLE);
  assign ack_n    = (st == S_IDLE) || (st == S_WREQ);
  assign rd_stb_n = !((st == S_STB) && !dir);
  assign wr_stb_n = !((st == S_STB) && dir);
  assign dd_oe    = dir && !ack_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      rem      <= '0;
      dir      <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      dd_out   <= '0;
    end else begin
      done <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (launch && dir) dd_out <= wr_data;

      case (st)
        S_IDLE: begin
          if (start) begin
            if (word_count == '0) begin
              done <= 1'b1;
            end else begin
              dir <= dir_wr;
              rem <= word_count;
              st  <= S_WREQ;
            end
          end
        end

        S_WREQ: if (req_s) st <= S_ARM;

        S_ARM: begin
          if (launch) begin
            st  <= S_STB;
            tmr <= TW'(ACT_CK - 1);
          end else if (!req_s) begin
            st   <= S_HOLD;
            tmr  <= TW'(ACKH_CK - 1);
            done <= 1'b1;
          end
        end

        S_STB: begin
          if (tmr == '0) begin
            st  <= S_NEG;
            tmr <= TW'(NEG_LEN - 1);
            rem <= rem - 1'b1;
            if (!dir) begin
              rd_data  <= dd_in;
              rd_valid <= 1'b1;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end

        S_NEG: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else if (!more) begin
            st   <= S_HOLD;
            tmr  <= TW'(ACKH_CK - 1);
            done <= 1'b1;
          end else if (data_ok) begin
            st  <= S_STB;
            tmr <= TW'(ACT_CK - 1);
          end else begin
            st <= S_ARM;
          end
        end

        S_HOLD: begin
          if (tmr == '0) st <= S_IDLE;
          else           tmr <= tmr - 1'b1;
        end

        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdma_host_seq_chk.sv
`timescale 1ns/1ps
module mdma_host_seq_chk #(
  parameter int P_ACT = 4,
  parameter int P_NEG = 4,
  parameter int DW    = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_n,
  input logic          rd_stb_n,
  input logic          wr_stb_n,
  input logic [DW-1:0] dd_out,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          done
);

  logic       stb_hi;
  logic [7:0] lo_cnt, hi_cnt;
  logic       seen;

  assign stb_hi = rd_stb_n && wr_stb_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      seen   <= 1'b0;
    end else begin
      lo_cnt <= stb_hi ? 8'd0 : ((lo_cnt == 8'hff) ? lo_cnt : lo_cnt + 8'd1);
      hi_cnt <= !stb_hi ? 8'd0 : ((hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 8'd1);
      if (ack_n)        seen <= 1'b0;
      else if (!stb_hi) seen <= 1'b1;
    end
  end

  assert_stb_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_hi) |-> (lo_cnt == 8'(P_ACT)));

  assert_stb_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stb_hi) && seen) |-> (hi_cnt >= 8'(P_NEG)));

  assert_ack_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_hi) |-> $past(!ack_n));

  assert_ack_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> $past(stb_hi));

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_n |=> $stable(dd_out));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind mdma_host_seq mdma_host_seq_chk #(.P_ACT(ACT_CK), .P_NEG(NEG_LEN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n),
  .dd_out(dd_out), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .done(done)
);

// File: tb/mdma_host_seq_tb_top.sv
`timescale 1ns/1ps
module mdma_host_seq_tb_top;

  localparam int EXP_LO  = 4;
  localparam int EXP_GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_wr = 1'b0;
  logic [15:0] word_count = '0;
  logic        busy, done;
  logic        dev_req = 1'b0;
  logic        ack_n, rd_stb_n, wr_stb_n;
  logic [15:0] dd_in = '0;
  logic [15:0] dd_out;
  logic        dd_oe;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;

  int checks = 0;
  int errs   = 0;

  int cmd_seq = 0, cmd_cnt = 0, cmd_budget = 0, cmd_mode = 0, cmd_dly = 0;
  bit cmd_dir = 0, cmd_poke = 0;
  int fin_seq = 0;

  always #10 clk = ~clk;

  mdma_host_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr), .word_count(word_count),
    .busy(busy), .done(done), .dev_req(dev_req), .ack_n(ack_n), .rd_stb_n(rd_stb_n),
    .wr_stb_n(wr_stb_n), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready)
  );

  function automatic logic [15:0] word_of(input int b, input int i);
    return 16'((b * 40503 + i * 9973) ^ 32'h0000A5C3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int  cyc = 0, phase = 0, seen = 0, dly = 0;
  int  dev_cnt = 0, pop_idx = 0, host_idx = 0, done_cnt = 0;
  int  lo_len = 0, hi_len = 0, since_rise = 0;
  bit  prev_s = 1, prev_ack_n = 1, stb_seen = 0, ack_seen = 0, poked = 0, drop_pend = 0;
  bit  wv_q = 0, wr_q = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      if (cyc == 2) begin
        chk(ack_n && rd_stb_n && wr_stb_n, "R1 strobes/ack", {ack_n, rd_stb_n, wr_stb_n}, 7);
        chk(!dd_oe && !busy && !rd_valid && !done, "R1 flags",
            {dd_oe, busy, rd_valid, done}, 0);
      end
    end else begin
      automatic bit s = rd_stb_n && wr_stb_n;
      start = 1'b0;
      if (wv_q && wr_q) host_idx++;
      if (done) done_cnt++;
      if (!ack_n) ack_seen = 1;
      if (drop_pend) begin dev_req = 1'b0; drop_pend = 0; end

      if (prev_s && !s) begin
        chk(!ack_n && !prev_ack_n, "R4 ack lead", {prev_ack_n, ack_n}, 0);
        if (stb_seen) chk(hi_len >= EXP_GAP, "R3 gap", hi_len, EXP_GAP);
        chk(cmd_dir ? rd_stb_n : wr_stb_n, "R11 strobe type", {rd_stb_n, wr_stb_n},
            cmd_dir ? 2 : 1);
        if (cmd_dir) chk(dd_oe, "R7 oe in write", dd_oe, 1);
        else         chk(!rd_valid, "R5 no strobe while full", rd_valid, 0);
        if (!cmd_dir) dd_in = word_of(cmd_seq, dev_cnt);
        if (cmd_mode == 0 && dev_cnt + 1 == cmd_budget) dev_req = 1'b0;
        if (cmd_poke && !poked) begin
          start = 1'b1; word_count = 16'd1; dir_wr = !cmd_dir; poked = 1;
        end
        stb_seen = 1;
        lo_len = 0;
      end

      if (!prev_s && s) begin
        chk(lo_len == EXP_LO, "R2 width", lo_len, EXP_LO);
        if (cmd_dir) begin
          chk(dd_out == word_of(cmd_seq, dev_cnt), "R6 write word", dd_out,
              word_of(cmd_seq, dev_cnt));
          chk(dd_oe, "R7 oe at negation", dd_oe, 1);
        end
        dev_cnt++;
        since_rise = 0;
        if (dev_cnt == cmd_budget) begin
          if (cmd_mode == 1) dev_req = 1'b0;
          if (cmd_mode == 2) drop_pend = 1;
        end
        hi_len = 0;
      end

      if (!prev_ack_n && ack_n) begin
        chk(s && since_rise >= 1, "R4 ack tail", since_rise, 1);
        chk(!dd_oe, "R7 oe release", dd_oe, 0);
        stb_seen = 0;
      end

      if (!s) lo_len++; else hi_len++;
      since_rise++;

      rd_ready = ($urandom % 4) != 0;
      if (rd_valid && rd_ready) begin
        chk(rd_data == word_of(cmd_seq, pop_idx), "R5 read word", rd_data,
            word_of(cmd_seq, pop_idx));
        pop_idx++;
      end

      if (cmd_dir && phase != 0 && host_idx < cmd_cnt) begin
        if (!wr_valid || (wv_q && wr_q)) wr_valid = ($urandom % 4) != 0;
        wr_data = word_of(cmd_seq, host_idx);
      end else begin
        wr_valid = 1'b0;
      end
      wv_q = wr_valid;
      wr_q = wr_ready;

      case (phase)
        0: if (cmd_seq != seen) begin
          seen = cmd_seq;
          dev_cnt = 0; pop_idx = 0; host_idx = 0; done_cnt = 0;
          ack_seen = 0; poked = 0; stb_seen = 0; drop_pend = 0; wv_q = 0;
          start = 1'b1; word_count = 16'(cmd_cnt); dir_wr = cmd_dir;
          dly = cmd_dly; dev_req = 1'b0;
          phase = 1;
        end
        1: if (dly == 0) begin dev_req = 1'b1; phase = 2; end else dly--;
        default: if (!busy && done_cnt > 0 && !rd_valid) begin
          automatic int n_exp = (cmd_cnt == 0) ? 0 :
                                ((cmd_cnt < cmd_budget) ? cmd_cnt : cmd_budget);
          if (cmd_budget < cmd_cnt) chk(dev_cnt == n_exp, "R9 early end count", dev_cnt, n_exp);
          else                      chk(dev_cnt == n_exp, "R8 word count", dev_cnt, n_exp);
          chk(done_cnt == 1, "R8 single done", done_cnt, 1);
          if (cmd_dir) chk(host_idx == n_exp, "R6 words taken", host_idx, n_exp);
          else         chk(pop_idx == n_exp, "R5 words delivered", pop_idx, n_exp);
          if (cmd_cnt == 0) chk(!ack_seen, "R10 no ack", ack_seen, 0);
          dev_req = 1'b0;
          fin_seq = seen;
          phase = 0;
        end
      endcase

      prev_s = s;
      prev_ack_n = ack_n;
    end
  end

  task automatic run(input bit d, input int cnt, input int budget, input int mode,
                     input bit poke, input int dl);
    cmd_dir = d; cmd_cnt = cnt; cmd_budget = budget; cmd_mode = mode;
    cmd_poke = poke; cmd_dly = dl;
    cmd_seq++;
    while (fin_seq != cmd_seq) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    automatic int unused_seed = $urandom(32'h5eed);
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    run(0, 5, 99, 0, 0, 0);
    run(1, 5, 99, 0, 0, 2);
    run(0, 6, 3, 0, 0, 1);
    run(0, 6, 3, 1, 0, 0);
    run(0, 6, 3, 2, 0, 3);
    run(1, 7, 2, 2, 0, 0);
    run(1, 7, 4, 1, 0, 1);
    run(0, 0, 99, 0, 0, 0);
    run(1, 1, 99, 0, 0, 0);
    run(1, 1, 1, 1, 0, 0);
    run(0, 4, 99, 0, 1, 1);
    run(1, 4, 99, 0, 1, 0);
    for (int k = 0; k < 40; k++)
      run(1'($urandom % 2), 1 + ($urandom % 12), 1 + ($urandom % 14), $urandom % 3, 0,
          $urandom % 4);
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=%0d expected=%0d", fin_seq, cmd_seq);
    $display("== %0d vectors applied, %0d miscompares ==", checks + 1, errs + 1);
    $finish;
  end

endmodule